// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Mode Sequencer

This block sits on the host side of an asynchronous low-power pseudo-SRAM. It drives only the power-management pins: the sleep pin (`zz_n`), the chip and write strobes, the byte enables and the address bus. It sequences every power-state change. After reset it holds the memory idle through the power-up wait. On a request it lowers the sleep pin, issues one register write that carries the new setting on the five lowest address bits, and raises the sleep pin so the setting takes effect. It then lowers the pin again to enter the chosen retention state and keeps it low for the minimum sleep time. A wake request raises the pin. If the memory had entered deep power-down, the block also waits out the long recovery time.

All time limits are given in nanoseconds and converted into clock cycles from the clock-period parameter, rounding up. The block keeps its own copy of the memory's effective mode. It reports that copy, and it also reports a four-bit map of which address quarters still hold the data they had before the last reset. One request can wait while another is being served. Malformed requests are refused with an error pulse.

Top module: `lpm_seq`

## Requirements
- R1: After reset, `ready` stays low and `cs_n`, `we_n` and `zz_n` stay high for ceil(PWRUP_NS/CLK_NS) cycles. `ready` then rises.
- R2: A program request (`req_op`=2) taken while awake lowers `zz_n`. ceil(ZZWE_NS/CLK_NS) cycles later it starts one write strobe (`cs_n`, `we_n`, `ub_n`, `lb_n` all low) lasting ceil(WP_NS/CLK_NS) cycles. `cs_n` is never low while `zz_n` is high.
- R3: During the register write, address bit 4 is 0 for deep power-down (`req_kind`=2) and 1 otherwise. Bit 3 is 1 for reduced memory size (`req_kind`=1). Bit 2 is the half select (0 bottom, 1 top). Bits 1..0 are the area code (00 full, 10 half, 11 quarter). All higher bits are zero. The address is zero whenever `zz_n` is high.
- R4: After the write, `zz_n` goes high for ceil(ZZHI_NS/CLK_NS) cycles and then low again. `ready` returns after ceil(ZZMIN_NS/CLK_NS) cycles of `zz_n` low, with `lp_active` high.
- R5: A request is refused with a one-cycle `err` pulse and no pin activity if it has `req_op`=3, or if it is a program request with area code 01 or `req_kind`=3.
- R6: One request that arrives while the block is busy is held and served afterwards. A request that arrives while that slot is occupied is refused with `err` and dropped.
- R7: A wake request (`req_op`=0) taken in low power raises `zz_n`. `ready` returns after 1 cycle of `zz_n` high. After deep power-down it returns after ceil(RECOV_NS/CLK_NS) cycles instead.
- R8: `valid_map` bit i covers address quarter i (the top two address bits). Entering deep power-down clears all four bits. Entering refresh or reduced size clears the quarters outside the kept region: half bottom keeps 0011, half top 1100, quarter bottom 0001, quarter top 1000, full keeps all.
- R9: `mode_now` shows the effective register in the R3 encoding. It takes the programmed value at the update. On wake it returns to 10000 unless reduced memory size is in force, in which case it keeps its value.
- R10: A program or sleep request taken while in low power first raises `zz_n` for the wake time of R7 and then runs its own sequence.
- R11: A wake request while awake causes no pin activity. Whenever `ready` is high, `cs_n` and `we_n` are high.
- R12: A sleep request (`req_op`=1) lowers `zz_n` with no register write and applies the R8 loss rule for the effective mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | 0 wake, 1 sleep, 2 program and sleep, 3 invalid |
| req_kind | input | 2 | 0 partial refresh, 1 reduced size, 2 deep power-down, 3 invalid |
| req_half | input | 1 | 0 bottom, 1 top |
| req_area | input | 2 | 00 full, 01 reserved, 10 half, 11 quarter |
| cs_n | output | 1 | Memory chip select, active low |
| we_n | output | 1 | Memory write enable, active low |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |
| zz_n | output | 1 | Memory low-power pin, active low |
| addr | output | AW | Memory address bus |
| ready | output | 1 | No sequence running and none waiting |
| err | output | 1 | Request refused, one-cycle pulse |
| lp_active | output | 1 | Memory is in a low-power state |
| valid_map | output | 4 | Quarters that still hold their data |
| mode_now | output | 5 | Effective mode register copy |

## Verification
A corrupted copy of the effective mode appears on `mode_now` in the cycle after the wake or register update that produced it. It also appears in the wake time that follows: a lost deep-power-down flag shortens the recovery from 30 to 1 cycle at the bench's settings. A wrong loss mask appears on `valid_map` in the cycle after the sleep entry. A sequencer state error shifts the measured lead, strobe, gap or sleep-length counts within the same request. A wrong slot decision appears as a missing or extra `err` one cycle after the offending request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        OP_WAKE  = 2'd0,
        OP_SLEEP = 2'd1,
        OP_SET   = 2'd2,
        OP_BAD   = 2'd3
    } lpm_op_e;

    typedef enum logic [1:0] {
        K_PAR = 2'd0,
        K_RMS = 2'd1,
        K_DPD = 2'd2,
        K_BAD = 2'd3
    } lpm_kind_e;

    typedef struct packed {
        lpm_op_e   op;
        lpm_kind_e kind;
        logic      half;
        logic [1:0] area;
    } lpm_req_t;

    typedef enum logic [2:0] {
        ST_PWRUP, ST_IDLE, ST_WAKE, ST_ZZLO, ST_WR, ST_WREC, ST_ZZHI, ST_SLEEP
    } lpm_st_e;

    localparam logic [1:0] AREA_FULL = 2'b00;
    localparam logic [1:0] AREA_RSV  = 2'b01;
    localparam logic [1:0] AREA_HALF = 2'b10;
    localparam logic [1:0] AREA_QTR  = 2'b11;
    localparam logic [4:0] MODE_DEFAULT = 5'b10000;

    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic req_bad(lpm_req_t r);
        return (r.op == OP_BAD) ||
               ((r.op == OP_SET) && ((r.area == AREA_RSV) || (r.kind == K_BAD)));
    endfunction

    function automatic logic [4:0] mode_code(logic dpd, logic rms, logic half, logic [1:0] area);
        return {~dpd, rms, half, area};
    endfunction

    // Quarters (by top two address bits) kept by a retention setting.
    function automatic logic [3:0] keep_mask(logic dpd, logic half, logic [1:0] area);
        if (dpd) return 4'b0000;
        case (area)
            AREA_HALF: return half ? 4'b1100 : 4'b0011;
            AREA_QTR:  return half ? 4'b1000 : 4'b0001;
            default:   return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/lpm_timer.sv
module lpm_timer #(
    parameter int unsigned W    = 8,
    parameter int unsigned INIT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= W'(INIT);
        else if (load)  cnt <= val;
        else if (!zero) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);
endmodule

// File: rtl/lpm_slot.sv
module lpm_slot
    import lpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  lpm_req_t req_in,
    input  logic     take,
    output logic     pend_v,
    output lpm_req_t pend,
    output logic     err
);
    logic accept;

    always_comb accept = req_valid && !req_bad(req_in) && (!pend_v || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
            err    <= 1'b0;
        end else begin
            err    <= req_valid && !accept;
            pend_v <= accept || (pend_v && !take);
            if (accept) pend <= req_in;
        end
    end

    p_take_only_pending_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> pend_v);
    p_bad_flagged_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bad(req_in)) |=> err);
endmodule

// File: rtl/lpm_track.sv
module lpm_track
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       prog,
    input  lpm_req_t   cur,
    input  logic       enter,
    input  logic       wake,
    output logic       lp,
    output logic       eff_dpd,
    output logic [4:0] mode_now,
    output logic [3:0] valid_map
);
    logic       e_rms, e_half;
    logic [1:0] e_area;

    always_ff @(posedge clk) begin
        if (rst) begin
            lp        <= 1'b0;
            eff_dpd   <= 1'b0;
            e_rms     <= 1'b0;
            e_half    <= 1'b0;
            e_area    <= AREA_FULL;
            valid_map <= 4'b1111;
        end else begin
            if (prog) begin
                eff_dpd <= (cur.kind == K_DPD);
                e_rms   <= (cur.kind == K_RMS);
                e_half  <= cur.half;
                e_area  <= cur.area;
            end
            if (enter) begin
                lp        <= 1'b1;
                valid_map <= valid_map & keep_mask(eff_dpd, e_half, e_area);
            end
            if (wake) begin
                lp      <= 1'b0;
                eff_dpd <= 1'b0;
                if (!e_rms) begin
                    e_half <= 1'b0;
                    e_area <= AREA_FULL;
                end
            end
        end
    end

    assign mode_now = mode_code(eff_dpd, e_rms, e_half, e_area);

    p_dpd_wipes_r8: assert property (@(posedge clk) disable iff (rst)
        (enter && eff_dpd) |=> (valid_map == 4'b0000));
    p_revert_r9: assert property (@(posedge clk) disable iff (rst)
        (wake && !e_rms) |=> (mode_now == MODE_DEFAULT));
    p_events_apart_r10: assert property (@(posedge clk) disable iff (rst)
        !(enter && wake));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int unsigned AW        = 20,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned PWRUP_NS  = 150000,
    parameter int unsigned ZZWE_NS   = 100,
    parameter int unsigned WP_NS     = 60,
    parameter int unsigned ZZHI_NS   = 100,
    parameter int unsigned ZZMIN_NS  = 10000,
    parameter int unsigned RECOV_NS  = 150000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_kind,
    input  logic          req_half,
    input  logic [1:0]    req_area,
    output logic          cs_n,
    output logic          we_n,
    output logic          ub_n,
    output logic          lb_n,
    output logic          zz_n,
    output logic [AW-1:0] addr,
    output logic          ready,
    output logic          err,
    output logic          lp_active,
    output logic [3:0]    valid_map,
    output logic [4:0]    mode_now
);
    localparam int unsigned CY_PWRUP = ns2cyc(PWRUP_NS, CLK_NS);
    localparam int unsigned CY_ZZWE  = ns2cyc(ZZWE_NS,  CLK_NS);
    localparam int unsigned CY_WP    = ns2cyc(WP_NS,    CLK_NS);
    localparam int unsigned CY_ZZHI  = ns2cyc(ZZHI_NS,  CLK_NS);
    localparam int unsigned CY_ZZMIN = ns2cyc(ZZMIN_NS, CLK_NS);
    localparam int unsigned CY_RECOV = ns2cyc(RECOV_NS, CLK_NS);
    localparam int unsigned CY_MAX   = max2(max2(max2(CY_PWRUP, CY_RECOV), max2(CY_ZZMIN, CY_ZZHI)),
                                            max2(CY_ZZWE, CY_WP));
    localparam int unsigned TW       = $clog2(CY_MAX + 1);

    lpm_st_e  state, state_n;
    lpm_req_t req_in, pend, cur;
    logic     pend_v, take, tload, tzero, eff_dpd, lp;
    logic     prog, enter, wake;
    logic [TW-1:0] tval;

    always_comb req_in = '{op: lpm_op_e'(req_op), kind: lpm_kind_e'(req_kind),
                           half: req_half, area: req_area};

    lpm_slot u_slot (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
        .take(take), .pend_v(pend_v), .pend(pend), .err(err)
    );

    lpm_timer #(.W(TW), .INIT(CY_PWRUP)) u_timer (
        .clk(clk), .rst(rst), .load(tload), .val(tval), .zero(tzero)
    );

    lpm_track u_track (
        .clk(clk), .rst(rst), .prog(prog), .cur(cur), .enter(enter), .wake(wake),
        .lp(lp), .eff_dpd(eff_dpd), .mode_now(mode_now), .valid_map(valid_map)
    );

    // Next state, slot take, and timer load on every state entry.
    always_comb begin
        state_n = state;
        take    = 1'b0;
        case (state)
            ST_PWRUP: if (tzero) state_n = ST_IDLE;
            ST_IDLE: if (pend_v) begin
                take = 1'b1;
                if (lp)                      state_n = ST_WAKE;
                else if (pend.op == OP_SET)  state_n = ST_ZZLO;
                else if (pend.op == OP_SLEEP) state_n = ST_SLEEP;
            end
            ST_WAKE: if (tzero) begin
                if (cur.op == OP_SET)        state_n = ST_ZZLO;
                else if (cur.op == OP_SLEEP) state_n = ST_SLEEP;
                else                         state_n = ST_IDLE;
            end
            ST_ZZLO:  if (tzero) state_n = ST_WR;
            ST_WR:    if (tzero) state_n = ST_WREC;
            ST_WREC:  state_n = ST_ZZHI;
            ST_ZZHI:  if (tzero) state_n = ST_SLEEP;
            ST_SLEEP: if (tzero) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase

        tload = (state_n != state);
        case (state_n)
            ST_WAKE:  tval = eff_dpd ? TW'(CY_RECOV - 1) : '0;
            ST_ZZLO:  tval = TW'(CY_ZZWE - 1);
            ST_WR:    tval = TW'(CY_WP - 1);
            ST_ZZHI:  tval = TW'(CY_ZZHI - 1);
            ST_SLEEP: tval = TW'(CY_ZZMIN - 1);
            default:  tval = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PWRUP;
            cur   <= '0;
        end else begin
            state <= state_n;
            if (take) cur <= pend;
        end
    end

    always_comb begin
        prog  = (state == ST_WREC);
        enter = (state_n == ST_SLEEP) && (state != ST_SLEEP);
        wake  = (state_n == ST_WAKE) && (state != ST_WAKE);
    end

    // Pin decode from the registered state.
    always_comb begin
        cs_n = (state != ST_WR);
        we_n = (state != ST_WR);
        ub_n = (state != ST_WR);
        lb_n = (state != ST_WR);
        zz_n = !((state == ST_ZZLO) || (state == ST_WR) || (state == ST_WREC) ||
                 (state == ST_SLEEP) || (state == ST_IDLE && lp));
        addr = '0;
        if (state == ST_ZZLO || state == ST_WR || state == ST_WREC)
            addr[4:0] = mode_code(cur.kind == K_DPD, cur.kind == K_RMS, cur.half, cur.area);
        ready     = (state == ST_IDLE) && !pend_v;
        lp_active = lp;
    end

    p_cs_needs_zz_r2: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !zz_n);
    p_addr_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        zz_n |-> (addr == '0));
    p_addr_upper_r3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (addr[AW-1:5] == '0));
    p_no_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (addr[1:0] != AREA_RSV));
    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cs_n && we_n));
endmodule

// File: tb/sim_lpm_seq.sv
`timescale 1ns/1ps
module sim_lpm_seq;
    localparam int E_PW = 50, E_ZZWE = 3, E_WP = 6, E_HI = 4, E_MIN = 20, E_REC = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0, req_kind = 2'd0, req_area = 2'd0;
    logic req_half = 1'b0;
    logic cs_n, we_n, ub_n, lb_n, zz_n, ready, err, lp_active;
    logic [19:0] addr;
    logic [3:0] valid_map;
    logic [4:0] mode_now;

    int checks = 0, errors = 0;
    bit finished = 0;

    int m_err, m_nwr, m_wrlen, m_lead, m_hib, m_post, m_tail, m_rechi, m_zzlo;
    logic [19:0] m_addr;

    always #5 clk = ~clk;

    lpm_seq #(.AW(20), .CLK_NS(10), .PWRUP_NS(500), .ZZWE_NS(30), .WP_NS(60),
              .ZZHI_NS(40), .ZZMIN_NS(200), .RECOV_NS(300)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_kind(req_kind),
        .req_half(req_half), .req_area(req_area), .cs_n(cs_n), .we_n(we_n), .ub_n(ub_n),
        .lb_n(lb_n), .zz_n(zz_n), .addr(addr), .ready(ready), .err(err),
        .lp_active(lp_active), .valid_map(valid_map), .mode_now(mode_now)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] mask_of(int kind, int half, int area);
        if (kind == 2) return 4'b0000;
        if (area == 2) return half ? 4'b1100 : 4'b0011;
        if (area == 3) return half ? 4'b1000 : 4'b0001;
        return 4'b1111;
    endfunction

    function automatic logic [4:0] code_of(int kind, int half, int area);
        return {kind != 2, kind == 1, half[0], area[1:0]};
    endfunction

    task automatic do_reset();
        int low_cnt = 0, bad = 0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ready) break;
            low_cnt++;
            if (!cs_n || !zz_n || !we_n) bad++;
        end
        chk(low_cnt == E_PW, "R1 power-up wait", low_cnt, E_PW);
        chk(bad == 0, "R1 pins idle in power-up", bad, 0);
    endtask

    // Issue one request at a negedge and follow the pins until ready.
    task automatic issue(input int op, input int kind, input int half, input int area);
        int low_run = 0;
        bit seen_low = 0, seen_wr = 0, prev_we = 1, done = 0;
        m_nwr = 0; m_wrlen = 0; m_lead = -1; m_hib = 0; m_post = 0;
        m_tail = 0; m_rechi = 0; m_zzlo = 0; m_addr = '0;
        req_op = op[1:0]; req_kind = kind[1:0]; req_half = half[0]; req_area = area[1:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        m_err = int'(err);
        for (int i = 0; i < 2000 && !done; i++) begin
            if (ready) begin
                m_tail = low_run;
                done = 1;
            end else begin
                if (!we_n) begin
                    if (prev_we) begin
                        m_nwr++;
                        if (m_nwr == 1) m_lead = low_run;
                    end
                    m_wrlen++;
                    m_addr = addr;
                    seen_wr = 1;
                end
                if (!zz_n) begin
                    low_run++;
                    seen_low = 1;
                    m_zzlo++;
                end else begin
                    low_run = 0;
                    if (seen_low && !seen_wr) m_hib++;
                    if (seen_wr) m_post++;
                    m_rechi++;
                end
                prev_we = we_n;
                @(negedge clk);
            end
        end
        if (!done) chk(0, "watchdog on request", 0, 1);
    endtask

    initial begin
        logic [3:0] expv;
        // R11: wake while awake does nothing
        do_reset();
        issue(0, 0, 0, 0);
        chk(m_zzlo == 0 && m_nwr == 0, "R11 wake while awake quiet", m_zzlo + m_nwr, 0);
        chk(lp_active == 0, "R11 still awake", lp_active, 0);

        // Sweep all kinds, halves and area codes.
        for (int k = 0; k < 3; k++)
            for (int h = 0; h < 2; h++)
                for (int a = 0; a < 4; a++) begin
                    do_reset();
                    issue(2, k, h, a);
                    if (a == 1) begin
                        chk(m_err == 1, "R5 reserved area refused", m_err, 1);
                        chk(m_nwr == 0 && zz_n == 1, "R5 no pin activity", m_nwr, 0);
                        chk(valid_map == 4'hF, "R5 map untouched", valid_map, 15);
                        continue;
                    end
                    chk(m_err == 0, "R5 valid program accepted", m_err, 0);
                    chk(m_nwr == 1, "R2 one write strobe", m_nwr, 1);
                    chk(m_lead == E_ZZWE, "R2 zz low to write", m_lead, E_ZZWE);
                    chk(m_wrlen == E_WP, "R2 write width", m_wrlen, E_WP);
                    chk(m_addr == {15'b0, code_of(k, h, a)}, "R3 address code",
                        int'(m_addr), int'(code_of(k, h, a)));
                    chk(m_post == E_HI, "R4 update gap", m_post, E_HI);
                    chk(m_tail == E_MIN, "R4 minimum sleep", m_tail, E_MIN);
                    chk(lp_active == 1, "R4 in low power", lp_active, 1);
                    expv = mask_of(k, h, a);
                    chk(valid_map == expv, "R8 valid map", valid_map, expv);
                    chk(mode_now == code_of(k, h, a), "R9 programmed mode", mode_now,
                        code_of(k, h, a));
                    issue(0, 0, 0, 0);
                    chk(m_rechi == ((k == 2) ? E_REC : 1), "R7 wake time", m_rechi,
                        (k == 2) ? E_REC : 1);
                    chk(lp_active == 0 && zz_n == 1, "R7 awake", lp_active, 0);
                    chk(mode_now == ((k == 1) ? code_of(k, h, a) : 5'b10000), "R9 mode after wake",
                        mode_now, (k == 1) ? code_of(k, h, a) : 5'b10000);
                    issue(1, 0, 0, 0);
                    chk(m_nwr == 0, "R12 sleep without write", m_nwr, 0);
                    chk(m_tail == E_MIN && lp_active == 1, "R12 sleep held", m_tail, E_MIN);
                    chk(valid_map == expv, "R12 effective mask", valid_map, expv);
                end

        // R10: program from deep power-down wakes first with recovery.
        do_reset();
        issue(2, 2, 0, 0);
        issue(2, 0, 1, 2);
        chk(m_hib == E_REC, "R10 recovery before program", m_hib, E_REC);
        chk(m_nwr == 1 && m_lead == E_ZZWE, "R10 program follows", m_lead, E_ZZWE);
        chk(valid_map == 4'b0000, "R8 deep power-down clears", valid_map, 0);

        // R10: program from partial refresh low power: short wake.
        do_reset();
        issue(2, 0, 0, 3);
        issue(2, 1, 1, 2);
        chk(m_hib == 1, "R10 short wake before program", m_hib, 1);
        chk(valid_map == 4'b0000, "R8 masks accumulate", valid_map, 0);

        // R5: invalid op and invalid kind.
        do_reset();
        issue(3, 0, 0, 0);
        chk(m_err == 1 && m_nwr == 0, "R5 op 3 refused", m_err, 1);
        issue(2, 3, 0, 0);
        chk(m_err == 1 && m_nwr == 0, "R5 kind 3 refused", m_err, 1);

        // R6: slot hold and overflow.
        do_reset();
        @(negedge clk);
        req_op = 2'd2; req_kind = 2'd0; req_half = 1'b0; req_area = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        chk(err == 0, "R6 first accepted", err, 0);
        req_op = 2'd0;
        @(negedge clk);
        chk(err == 0, "R6 second held", err, 0);
        req_op = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1, "R6 overflow refused", err, 1);
        for (int i = 0; i < 300; i++) begin
            if (ready) break;
            @(negedge clk);
        end
        chk(lp_active == 0 && zz_n == 1, "R6 held wake served", lp_active, 0);
        repeat (10) @(negedge clk);
        chk(lp_active == 0 && ready == 1, "R6 dropped request not run", lp_active, 0);
        chk(valid_map == 4'hF, "R8 full refresh keeps all", valid_map, 15);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule